// File: doc/BRIEF.md
# Interrupt Translation Unit Register Frontend

This block is the register-facing side of an interrupt translation unit. It holds the control frame that software programs: an enable flag, the base of the command queue, a write pointer that software advances, a read pointer that the command engine advances, and a small bank of table base registers. Each control register is reachable with 32-bit half accesses or with whole 64-bit accesses. A second, separate frame takes doorbell writes from devices and turns each accepted one into a single-cycle event for the translation logic.

Configuration is locked while the unit runs. The queue base and the table bases accept writes only while the unit is disabled. A queue base write rewinds the read pointer and leaves the write pointer alone. Turning the unit on rewinds nothing and tells the command engine to start. A table slot whose value is zero counts as absent, so it stays zero whatever is written to it. No access, in either frame, returns an error: bad offsets and write-only registers read as zero.

Top module: `itu_reg_frontend`

## Requirements
- R1: After reset the enable flag, queue base, write pointer and read pointer read 0. Table slot i for i < NUM_IMPL reads (i+1) in bits 63:56 with all other bits 0, and every other slot reads 0. start_kick and db_valid are low.
- R2: A queue base write (offset 0x080 for 64-bit or low half, 0x084 for high half) takes effect only while the unit is disabled. When it takes effect it sets the read pointer to 0, and it never changes the write pointer. While enabled it changes nothing.
- R3: A write of 1 to bit 0 of the control register (offset 0x000) while disabled enables the unit and leaves both pointers unchanged. It raises start_kick for exactly one cycle, in the cycle after the write. A write-pointer write (offset 0x088) while enabled raises the same pulse. Disabling the unit changes neither pointer and gives no pulse.
- R4: A table slot (offset 0x100 + 8*i) is written only while the unit is disabled and only if its current value is non-zero. A zero slot reads 0 after any write.
- R5: Bits 63:56 of every table slot are read-only and keep their value across any write. A 32-bit write to the high half (slot offset + 4) lands in bits 63:32.
- R6: Any read in the translation frame completes with xl_rvalid one cycle later and xl_rdata = 0.
- R7: A control frame read of an unmapped or misaligned offset returns 0 with ctl_rvalid one cycle later. A write to such an offset, or to the read pointer (offset 0x090), changes no register.
- R8: A translation frame write to offset 0x040 with xl_size of 2, 3 or 4 bytes, made while enabled, gives db_valid for one cycle in the next cycle. db_data is the write data masked to the given byte count and db_rid is the requester ID. Any other size, any other offset, or a disabled unit gives no event.
- R9: An rp_upd_valid pulse loads rp_upd_val into the read pointer, unless a queue base write takes effect in the same cycle. The queue base write wins.
- R10: A 32-bit read returns the addressed half in ctl_rdata[31:0], with bits 63:32 zero. A 64-bit read returns the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_req | input | 1 | Control frame access strobe |
| ctl_we | input | 1 | Control frame write (1) or read (0) |
| ctl_is64 | input | 1 | 64-bit access when 1, 32-bit when 0 |
| ctl_addr | input | ADDR_W | Control frame byte offset |
| ctl_wdata | input | 64 | Control frame write data (32-bit writes use bits 31:0) |
| ctl_rvalid | output | 1 | Read data valid, one cycle after a read |
| ctl_rdata | output | 64 | Read data |
| rp_upd_valid | input | 1 | Read pointer update from the command engine |
| rp_upd_val | input | 64 | New read pointer value |
| start_kick | output | 1 | One-cycle request to start queue processing |
| xl_req | input | 1 | Translation frame access strobe |
| xl_we | input | 1 | Translation frame write (1) or read (0) |
| xl_addr | input | ADDR_W | Translation frame byte offset |
| xl_size | input | 3 | Access size in bytes |
| xl_wdata | input | 32 | Translation frame write data |
| xl_rid | input | RID_W | Requester ID of the access |
| xl_rvalid | output | 1 | Translation frame read completion |
| xl_rdata | output | 32 | Translation frame read data (always 0) |
| db_valid | output | 1 | Doorbell event |
| db_data | output | 32 | Doorbell data, masked to the access size |
| db_rid | output | RID_W | Requester ID of the doorbell |

## Verification
Every result appears one cycle after its stimulus: register writes commit at the next edge, while read data, start_kick and the doorbell event are registered outputs that are valid in the cycle after the request. The bench drives each request on a falling edge and holds it across one rising edge. It samples on the following falling edge, where the registered result is stable. Read and doorbell expectations go into queues when the request is driven. A monitor pops them each time ctl_rvalid, xl_rvalid or db_valid appears, so an unexpected or missing response fails a check. start_kick is sampled directly after each control write.

// File: rtl/itu_pkg.sv
package itu_pkg;

  // Control frame byte offsets
  localparam int OFF_CTRL     = 'h000;
  localparam int OFF_QBASE    = 'h080;
  localparam int OFF_QWPTR    = 'h088;
  localparam int OFF_QRPTR    = 'h090;
  localparam int OFF_TBL      = 'h100;
  // Translation frame doorbell offset
  localparam int OFF_DOORBELL = 'h040;

  // Read-only field of every table slot
  localparam logic [63:0] TBL_RO_MASK = 64'hFF00_0000_0000_0000;

  // Merge a 32-bit half or 64-bit write into a register, keeping read-only bits
  function automatic logic [63:0] merge_word(input logic [63:0] old,
                                             input logic [63:0] wdata,
                                             input logic        hi,
                                             input logic        is64,
                                             input logic [63:0] ro);
    logic [63:0] lane;
    logic [63:0] shifted;
    logic [63:0] wmask;
    if (is64) begin
      lane    = '1;
      shifted = wdata;
    end else if (hi) begin
      lane    = {32'hFFFF_FFFF, 32'h0};
      shifted = {wdata[31:0], 32'h0};
    end else begin
      lane    = {32'h0, 32'hFFFF_FFFF};
      shifted = {32'h0, wdata[31:0]};
    end
    wmask = lane & ~ro;
    return (old & ~wmask) | (shifted & wmask);
  endfunction

  // Select the read lane of a register
  function automatic logic [63:0] lane_read(input logic [63:0] val,
                                            input logic        hi,
                                            input logic        is64);
    if (is64)    return val;
    else if (hi) return {32'h0, val[63:32]};
    else         return {32'h0, val[31:0]};
  endfunction

  function automatic logic size_ok(input logic [2:0] size);
    return (size >= 3'd2) && (size <= 3'd4);
  endfunction

  function automatic logic [31:0] size_mask(input logic [2:0] size);
    case (size)
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  // Reset value of table slot idx: implemented slots carry a non-zero tag
  function automatic logic [63:0] tbl_rst(input int idx, input int nimpl);
    if (idx < nimpl) return {8'(idx + 1), 56'h0};
    else             return 64'h0;
  endfunction

endpackage

// File: rtl/itu_ctl_regs.sv
module itu_ctl_regs
  import itu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_qbase,
  input  logic        wr_wptr,
  input  logic        wr_hi,
  input  logic        wr_is64,
  input  logic [63:0] wdata,
  input  logic        rp_upd_valid,
  input  logic [63:0] rp_upd_val,
  output logic        enable_q,
  output logic [63:0] qbase_q,
  output logic [63:0] wptr_q,
  output logic [63:0] rptr_q,
  output logic        start_kick,
  output logic        qbase_wr_evt,
  output logic        en_rise_evt
);

  logic ctrl_lo_wr;
  logic kick_d;

  // The enable flag sits in the low half; a high-half write has no field
  assign ctrl_lo_wr   = wr_ctrl && (wr_is64 || !wr_hi);
  assign qbase_wr_evt = wr_qbase && !enable_q;
  assign en_rise_evt  = ctrl_lo_wr && wdata[0] && !enable_q;
  assign kick_d       = en_rise_evt || (wr_wptr && enable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      qbase_q    <= '0;
      wptr_q     <= '0;
      rptr_q     <= '0;
      start_kick <= 1'b0;
    end else begin
      start_kick <= kick_d;
      if (ctrl_lo_wr) enable_q <= wdata[0];
      if (qbase_wr_evt) qbase_q <= merge_word(qbase_q, wdata, wr_hi, wr_is64, 64'h0);
      if (wr_wptr) wptr_q <= merge_word(wptr_q, wdata, wr_hi, wr_is64, 64'h0);
      if (qbase_wr_evt)      rptr_q <= '0;
      else if (rp_upd_valid) rptr_q <= rp_upd_val;
    end
  end

endmodule

// File: rtl/itu_tbl_bank.sv
module itu_tbl_bank
  import itu_pkg::*;
#(
  parameter int NUM_TBL  = 4,
  parameter int NUM_IMPL = 2,
  localparam int SLOT_W  = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic                    wr_hi,
  input  logic                    wr_is64,
  input  logic [63:0]             wdata,
  input  logic                    enable_q,
  output logic [NUM_TBL*64-1:0]   tbl_flat
);

  for (genvar i = 0; i < NUM_TBL; i++) begin : g_slot
    localparam logic [63:0] RST_VAL = tbl_rst(i, NUM_IMPL);
    logic [63:0] val_q;
    logic        hit;

    // A zero slot is absent: it can never be written
    assign hit = wr_en && (wr_slot == SLOT_W'(i)) && !enable_q && (val_q != 64'h0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RST_VAL;
      else if (hit) val_q <= merge_word(val_q, wdata, wr_hi, wr_is64, TBL_RO_MASK);
    end

    assign tbl_flat[i*64 +: 64] = val_q;
  end

endmodule

// File: rtl/itu_xlat_frame.sv
module itu_xlat_frame
  import itu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_q,
  input  logic              xl_req,
  input  logic              xl_we,
  input  logic [ADDR_W-1:0] xl_addr,
  input  logic [2:0]        xl_size,
  input  logic [31:0]       xl_wdata,
  input  logic [RID_W-1:0]  xl_rid,
  output logic              xl_rvalid,
  output logic [31:0]       xl_rdata,
  output logic              db_valid,
  output logic [31:0]       db_data,
  output logic [RID_W-1:0]  db_rid
);

  localparam logic [ADDR_W-1:0] A_DB = ADDR_W'(OFF_DOORBELL);

  logic db_fire;

  assign db_fire = xl_req && xl_we && (xl_addr == A_DB) && size_ok(xl_size) && enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_rvalid <= 1'b0;
      db_valid  <= 1'b0;
      db_data   <= '0;
      db_rid    <= '0;
    end else begin
      xl_rvalid <= xl_req && !xl_we;
      db_valid  <= db_fire;
      if (db_fire) begin
        db_data <= xl_wdata & size_mask(xl_size);
        db_rid  <= xl_rid;
      end
    end
  end

  // The doorbell is write-only; everything in this frame reads as zero
  assign xl_rdata = 32'h0;

endmodule

// File: rtl/itu_reg_frontend.sv
module itu_reg_frontend
  import itu_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_TBL  = 4,
  parameter int NUM_IMPL = 2,
  parameter int RID_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_req,
  input  logic              ctl_we,
  input  logic              ctl_is64,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [63:0]       ctl_wdata,
  output logic              ctl_rvalid,
  output logic [63:0]       ctl_rdata,
  input  logic              rp_upd_valid,
  input  logic [63:0]       rp_upd_val,
  output logic              start_kick,
  input  logic              xl_req,
  input  logic              xl_we,
  input  logic [ADDR_W-1:0] xl_addr,
  input  logic [2:0]        xl_size,
  input  logic [31:0]       xl_wdata,
  input  logic [RID_W-1:0]  xl_rid,
  output logic              xl_rvalid,
  output logic [31:0]       xl_rdata,
  output logic              db_valid,
  output logic [31:0]       db_data,
  output logic [RID_W-1:0]  db_rid
);

  localparam int WORD_W = ADDR_W - 3;
  localparam int SLOT_W = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_QBASE = ADDR_W'(OFF_QBASE);
  localparam logic [ADDR_W-1:0] A_QWPTR = ADDR_W'(OFF_QWPTR);
  localparam logic [ADDR_W-1:0] A_QRPTR = ADDR_W'(OFF_QRPTR);
  localparam logic [ADDR_W-1:0] A_TBL   = ADDR_W'(OFF_TBL);

  // Decode
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] tbl_rel;
  logic              aligned;
  logic              hi;
  logic              hit_ctrl, hit_qbase, hit_wptr, hit_rptr, hit_tbl;
  logic [SLOT_W-1:0] slot;

  assign word      = ctl_addr[ADDR_W-1:3];
  assign aligned   = (ctl_addr[1:0] == 2'b00) && !(ctl_is64 && ctl_addr[2]);
  assign hi        = ctl_addr[2] && !ctl_is64;
  assign hit_ctrl  = aligned && (word == A_CTRL[ADDR_W-1:3]);
  assign hit_qbase = aligned && (word == A_QBASE[ADDR_W-1:3]);
  assign hit_wptr  = aligned && (word == A_QWPTR[ADDR_W-1:3]);
  assign hit_rptr  = aligned && (word == A_QRPTR[ADDR_W-1:3]);
  assign tbl_rel   = word - A_TBL[ADDR_W-1:3];
  assign hit_tbl   = aligned && (word >= A_TBL[ADDR_W-1:3]) && (tbl_rel < WORD_W'(NUM_TBL));
  assign slot      = tbl_rel[SLOT_W-1:0];

  logic wr_go;
  logic rd_go;
  assign wr_go = ctl_req && ctl_we;
  assign rd_go = ctl_req && !ctl_we;

  // Register state
  logic                  enable_q;
  logic [63:0]           qbase_q;
  logic [63:0]           wptr_q;
  logic [63:0]           rptr_q;
  logic                  qbase_wr_evt;
  logic                  en_rise_evt;
  logic [NUM_TBL*64-1:0] tbl_flat;

  itu_ctl_regs u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_go && hit_ctrl),
    .wr_qbase     (wr_go && hit_qbase),
    .wr_wptr      (wr_go && hit_wptr),
    .wr_hi        (hi),
    .wr_is64      (ctl_is64),
    .wdata        (ctl_wdata),
    .rp_upd_valid (rp_upd_valid),
    .rp_upd_val   (rp_upd_val),
    .enable_q     (enable_q),
    .qbase_q      (qbase_q),
    .wptr_q       (wptr_q),
    .rptr_q       (rptr_q),
    .start_kick   (start_kick),
    .qbase_wr_evt (qbase_wr_evt),
    .en_rise_evt  (en_rise_evt)
  );

  itu_tbl_bank #(
    .NUM_TBL  (NUM_TBL),
    .NUM_IMPL (NUM_IMPL)
  ) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_go && hit_tbl),
    .wr_slot  (slot),
    .wr_hi    (hi),
    .wr_is64  (ctl_is64),
    .wdata    (ctl_wdata),
    .enable_q (enable_q),
    .tbl_flat (tbl_flat)
  );

  itu_xlat_frame #(
    .ADDR_W (ADDR_W),
    .RID_W  (RID_W)
  ) u_xlat (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_q  (enable_q),
    .xl_req    (xl_req),
    .xl_we     (xl_we),
    .xl_addr   (xl_addr),
    .xl_size   (xl_size),
    .xl_wdata  (xl_wdata),
    .xl_rid    (xl_rid),
    .xl_rvalid (xl_rvalid),
    .xl_rdata  (xl_rdata),
    .db_valid  (db_valid),
    .db_data   (db_data),
    .db_rid    (db_rid)
  );

  // Read mux: unmapped offsets fall through to zero
  logic [63:0] rd_word;
  always_comb begin
    rd_word = 64'h0;
    if (hit_ctrl)       rd_word = {63'h0, enable_q};
    else if (hit_qbase) rd_word = qbase_q;
    else if (hit_wptr)  rd_word = wptr_q;
    else if (hit_rptr)  rd_word = rptr_q;
    else if (hit_tbl)   rd_word = tbl_flat[slot*64 +: 64];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_rvalid <= 1'b0;
      ctl_rdata  <= '0;
    end else begin
      ctl_rvalid <= rd_go;
      if (rd_go) ctl_rdata <= lane_read(rd_word, hi, ctl_is64);
    end
  end

endmodule

// File: rtl/itu_reg_frontend_chk.sv
module itu_reg_frontend_chk #(
  parameter int NUM_TBL = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable_q,
  input logic [63:0]           qbase_q,
  input logic [63:0]           wptr_q,
  input logic [63:0]           rptr_q,
  input logic [NUM_TBL*64-1:0] tbl_flat,
  input logic                  start_kick,
  input logic                  db_valid,
  input logic                  qbase_wr_evt,
  input logic                  en_rise_evt,
  input logic                  rp_upd_valid
);

  // R2: base is frozen while the unit stays enabled
  a_r2_qbase_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && $past(enable_q)) |-> $stable(qbase_q));

  // R2: an accepted base write rewinds the read pointer
  a_r2_base_rewinds_rptr: assert property (@(posedge clk) disable iff (!rst_n)
    qbase_wr_evt |=> (rptr_q == 64'h0));

  // R2: an accepted base write leaves the write pointer alone
  a_r2_base_keeps_wptr: assert property (@(posedge clk) disable iff (!rst_n)
    qbase_wr_evt |=> $stable(wptr_q));

  // R3: enabling rewinds neither pointer
  a_r3_enable_keeps_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise_evt && !rp_upd_valid) |=> ($stable(rptr_q) && $stable(wptr_q)));

  // R3: the start pulse only appears with the unit enabled
  a_r3_kick_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    start_kick |-> enable_q);

  // R4: table slots are frozen while the unit stays enabled
  a_r4_tbl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && $past(enable_q)) |-> $stable(tbl_flat));

  // R8: a doorbell event follows a cycle in which the unit was enabled
  a_r8_db_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> $past(enable_q));

  // R5: the read-only field of each slot never moves
  for (genvar i = 0; i < NUM_TBL; i++) begin : g_ro
    a_r5_ro_field_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(tbl_flat[i*64+56 +: 8]));
  end

endmodule

bind itu_reg_frontend itu_reg_frontend_chk #(.NUM_TBL(NUM_TBL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_q     (enable_q),
  .qbase_q      (qbase_q),
  .wptr_q       (wptr_q),
  .rptr_q       (rptr_q),
  .tbl_flat     (tbl_flat),
  .start_kick   (start_kick),
  .db_valid     (db_valid),
  .qbase_wr_evt (qbase_wr_evt),
  .en_rise_evt  (en_rise_evt),
  .rp_upd_valid (rp_upd_valid)
);

// File: tb/itu_reg_frontend_tb.sv
module itu_reg_frontend_tb;

  localparam int ADDR_W = 12;
  localparam int RID_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_req = 1'b0, ctl_we = 1'b0, ctl_is64 = 1'b0;
  logic [ADDR_W-1:0] ctl_addr = '0;
  logic [63:0]       ctl_wdata = '0;
  logic              ctl_rvalid;
  logic [63:0]       ctl_rdata;
  logic              rp_upd_valid = 1'b0;
  logic [63:0]       rp_upd_val = '0;
  logic              start_kick;
  logic              xl_req = 1'b0, xl_we = 1'b0;
  logic [ADDR_W-1:0] xl_addr = '0;
  logic [2:0]        xl_size = '0;
  logic [31:0]       xl_wdata = '0;
  logic [RID_W-1:0]  xl_rid = '0;
  logic              xl_rvalid;
  logic [31:0]       xl_rdata;
  logic              db_valid;
  logic [31:0]       db_data;
  logic [RID_W-1:0]  db_rid;

  itu_reg_frontend #(.ADDR_W(ADDR_W), .NUM_TBL(4), .NUM_IMPL(2), .RID_W(RID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_is64(ctl_is64),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata),
    .rp_upd_valid(rp_upd_valid), .rp_upd_val(rp_upd_val), .start_kick(start_kick),
    .xl_req(xl_req), .xl_we(xl_we), .xl_addr(xl_addr), .xl_size(xl_size),
    .xl_wdata(xl_wdata), .xl_rid(xl_rid), .xl_rvalid(xl_rvalid), .xl_rdata(xl_rdata),
    .db_valid(db_valid), .db_data(db_data), .db_rid(db_rid));

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Scoreboard queues
  logic [63:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [47:0] db_exp_q[$];   // {rid, data}
  string       db_tag_q[$];
  int          xl_pend = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: results are registered, so sample on the falling edge after them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ctl_rvalid) begin
        if (rd_exp_q.size() == 0) chk("R7 unexpected ctl_rvalid", 64'h1, 64'h0);
        else chk(rd_tag_q.pop_front(), ctl_rdata, rd_exp_q.pop_front());
      end
      if (db_valid) begin
        if (db_exp_q.size() == 0) chk("R8 unexpected db_valid", {16'h0, db_rid, db_data}, 64'h0);
        else chk(db_tag_q.pop_front(), {16'h0, db_rid, db_data}, {16'h0, db_exp_q.pop_front()});
      end
      if (xl_rvalid) begin
        if (xl_pend == 0) chk("R6 unexpected xl_rvalid", 64'h1, 64'h0);
        else begin
          xl_pend--;
          chk("R6 xlat read data", {32'h0, xl_rdata}, 64'h0);
        end
      end
    end
  end

  // Driver tasks: entered on a falling edge, hold inputs across one rising edge
  task automatic ctl_wr(input logic [ADDR_W-1:0] a, input logic [63:0] d, input logic w64);
    ctl_req = 1; ctl_we = 1; ctl_is64 = w64; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_req = 0; ctl_we = 0;
  endtask

  task automatic ctl_rd(input logic [ADDR_W-1:0] a, input logic w64,
                        input logic [63:0] exp, input string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    ctl_req = 1; ctl_we = 0; ctl_is64 = w64; ctl_addr = a;
    @(negedge clk);
    ctl_req = 0;
  endtask

  task automatic rp_set(input logic [63:0] v);
    rp_upd_valid = 1; rp_upd_val = v;
    @(negedge clk);
    rp_upd_valid = 0;
  endtask

  task automatic xl_wr(input logic [ADDR_W-1:0] a, input logic [2:0] sz, input logic [31:0] d,
                       input logic [RID_W-1:0] rid, input logic fire, input logic [31:0] exp_d,
                       input string tag);
    if (fire) begin
      db_exp_q.push_back({rid, exp_d});
      db_tag_q.push_back(tag);
    end
    xl_req = 1; xl_we = 1; xl_addr = a; xl_size = sz; xl_wdata = d; xl_rid = rid;
    @(negedge clk);
    xl_req = 0; xl_we = 0;
  endtask

  task automatic xl_rd(input logic [ADDR_W-1:0] a);
    xl_pend++;
    xl_req = 1; xl_we = 0; xl_addr = a; xl_size = 3'd4;
    @(negedge clk);
    xl_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 start_kick idle", {63'h0, start_kick}, 64'h0);
    chk("R1 db_valid idle", {63'h0, db_valid}, 64'h0);
    ctl_rd(12'h000, 1, 64'h0, "R1 ctrl reset");
    ctl_rd(12'h080, 1, 64'h0, "R1 qbase reset");
    ctl_rd(12'h088, 1, 64'h0, "R1 wptr reset");
    ctl_rd(12'h090, 1, 64'h0, "R1 rptr reset");
    ctl_rd(12'h100, 1, 64'h0100_0000_0000_0000, "R1 tbl0 reset");
    ctl_rd(12'h108, 1, 64'h0200_0000_0000_0000, "R1 tbl1 reset");
    ctl_rd(12'h110, 1, 64'h0, "R1 tbl2 absent");
    ctl_rd(12'h118, 1, 64'h0, "R1 tbl3 absent");

    // R9 engine update of read pointer
    rp_set(64'h5);
    ctl_rd(12'h090, 1, 64'h5, "R9 rptr update");

    // R2 base writes while disabled
    ctl_wr(12'h088, 64'h40, 1);
    chk("R3 no kick when disabled", {63'h0, start_kick}, 64'h0);
    ctl_wr(12'h080, 64'h1234_0000, 1);
    ctl_rd(12'h090, 1, 64'h0, "R2 64b base clears rptr");
    ctl_rd(12'h088, 1, 64'h40, "R2 base keeps wptr");
    ctl_rd(12'h080, 1, 64'h1234_0000, "R2 base value");
    rp_set(64'h7);
    ctl_wr(12'h080, 64'hAAAA_0000, 0);
    ctl_rd(12'h090, 1, 64'h0, "R2 low-half base clears rptr");
    rp_set(64'h9);
    ctl_wr(12'h084, 64'h55, 0);
    ctl_rd(12'h090, 1, 64'h0, "R2 high-half base clears rptr");
    ctl_rd(12'h080, 1, 64'h0000_0055_AAAA_0000, "R2 halves merged");
    ctl_rd(12'h088, 1, 64'h40, "R2 wptr still kept");

    // R5 read-only field and high-half placement; R10 lane reads
    ctl_wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    ctl_rd(12'h100, 1, 64'h01FF_FFFF_FFFF_FFFF, "R5 ro field kept on 64b write");
    ctl_wr(12'h108, 64'h1111_2222, 0);
    ctl_wr(12'h10C, 64'hABCD_EF01, 0);
    ctl_rd(12'h108, 1, 64'h02CD_EF01_1111_2222, "R5 high half shifted, ro kept");
    ctl_rd(12'h10C, 0, 64'h0000_0000_02CD_EF01, "R10 32b high read");
    ctl_rd(12'h108, 0, 64'h0000_0000_1111_2222, "R10 32b low read");

    // R4 absent slot ignores writes
    ctl_wr(12'h110, 64'hDEAD, 1);
    ctl_rd(12'h110, 1, 64'h0, "R4 absent slot stays zero");

    // R7 invalid offsets and read-only pointer
    ctl_wr(12'h300, 64'hFFFF, 1);
    ctl_rd(12'h300, 1, 64'h0, "R7 unmapped read zero");
    ctl_rd(12'h081, 0, 64'h0, "R7 misaligned read zero");
    ctl_wr(12'h090, 64'h77, 1);
    ctl_rd(12'h090, 1, 64'h0, "R7 rptr write ignored");
    ctl_rd(12'h080, 1, 64'h0000_0055_AAAA_0000, "R7 base untouched");

    // R8 doorbell ignored while disabled
    xl_wr(12'h040, 3'd4, 32'hCAFE_F00D, 16'h0011, 0, 32'h0, "");
    chk("R8 no doorbell while disabled", {63'h0, db_valid}, 64'h0);

    // R3 enable: pulse, pointers kept
    rp_set(64'h3);
    ctl_wr(12'h000, 64'h1, 0);
    chk("R3 kick on enable", {63'h0, start_kick}, 64'h1);
    @(negedge clk);
    chk("R3 kick one cycle", {63'h0, start_kick}, 64'h0);
    ctl_rd(12'h090, 1, 64'h3, "R3 enable keeps rptr");
    ctl_rd(12'h088, 1, 64'h40, "R3 enable keeps wptr");
    ctl_wr(12'h000, 64'h1, 0);
    chk("R3 no kick when already enabled", {63'h0, start_kick}, 64'h0);

    // R2 / R4 locked while enabled
    ctl_wr(12'h080, 64'h999, 1);
    ctl_rd(12'h080, 1, 64'h0000_0055_AAAA_0000, "R2 base locked when enabled");
    ctl_rd(12'h090, 1, 64'h3, "R2 locked base keeps rptr");
    ctl_wr(12'h100, 64'h0, 1);
    ctl_rd(12'h100, 1, 64'h01FF_FFFF_FFFF_FFFF, "R4 slot locked when enabled");

    // R3 write pointer kick
    ctl_wr(12'h088, 64'h60, 1);
    chk("R3 kick on wptr write", {63'h0, start_kick}, 64'h1);
    ctl_rd(12'h088, 1, 64'h60, "R3 wptr value");

    // R8 doorbells
    xl_wr(12'h040, 3'd4, 32'h1234_5678, 16'h0021, 1, 32'h1234_5678, "R8 doorbell 4 bytes");
    xl_wr(12'h040, 3'd2, 32'hFFFF_ABCD, 16'h0022, 1, 32'h0000_ABCD, "R8 doorbell 2 bytes");
    xl_wr(12'h040, 3'd3, 32'h12AB_CDEF, 16'h0023, 1, 32'h00AB_CDEF, "R8 doorbell 3 bytes");
    xl_wr(12'h040, 3'd1, 32'h0000_00FF, 16'h0024, 0, 32'h0, "");
    chk("R8 size 1 ignored", {63'h0, db_valid}, 64'h0);
    xl_wr(12'h044, 3'd4, 32'h0000_00FF, 16'h0025, 0, 32'h0, "");
    chk("R8 wrong offset ignored", {63'h0, db_valid}, 64'h0);

    // R6 translation frame reads
    xl_rd(12'h040);
    xl_rd(12'h100);

    // R3 disable: no pulse, pointers kept; R8 doorbell ignored again
    ctl_wr(12'h000, 64'h0, 0);
    chk("R3 no kick on disable", {63'h0, start_kick}, 64'h0);
    ctl_rd(12'h000, 1, 64'h0, "R3 disabled state");
    ctl_rd(12'h090, 1, 64'h3, "R3 disable keeps rptr");
    xl_wr(12'h040, 3'd4, 32'h5555_5555, 16'h0026, 0, 32'h0, "");
    chk("R8 no doorbell after disable", {63'h0, db_valid}, 64'h0);

    repeat (3) @(negedge clk);
    chk("scoreboard ctl reads drained", 64'(rd_exp_q.size()), 64'h0);
    chk("R8 scoreboard doorbells drained", 64'(db_exp_q.size()), 64'h0);
    chk("R6 scoreboard xlat reads drained", 64'(xl_pend), 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule